// File: doc/BRIEF.md
# Platform Power-State Sequencer

This block is the digital half of a platform power controller. It sits between a host SoC and the power stages. It turns the host's sleep requests and acknowledgements into enable commands for three groups of rails: the always-on suspend rails, the memory rail and the core rails. It also drives the resume-reset and power-good indications back to the host. Analog regulation is not part of the block. Each rail reports its state on a single digital "at nominal" input.

Every asynchronous input passes through a two-stage synchronizer. After reset the sequencer waits in G3 with everything off. A wake edge starts power-up, provided the battery flag is good. The suspend rails come up first. The host then controls the S4, Sx and S0 transitions through its active-low S4 request. Power-up always runs memory first, then the core rails, then the power-good outputs. Sleep entry undoes these steps in the opposite order. It can begin only when the host pulls both its platform reset and its idle request low. A separate acknowledge, given while the host holds S4, removes the suspend rails and returns the block to G3. If a rail loses its good flag while it is enabled, the block shuts everything down at once.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: `batt_low_n` follows `batt_ok`. A change applied before clock edge k is visible after edge k+2. It is low out of reset.
- R2: In G3, a rising edge on `wake_req` while `batt_ok` is high turns on every bit of `sus_en`. A wake edge while `batt_ok` is low leaves all enables off.
- R3: `rsm_rst_n` is low in G3. It goes high only while `sus_en[0]` (the 3.3 V always-on rail) is on and `sus_good[0]` is high.
- R4: With the suspend rails good and `rsm_rst_n` high, a rising edge on `s4_req_n` first turns on `mem_en`. Once `mem_good` is high, every bit of `core_en` turns on. Once all rails report good, `vcca_pgood` and `core_pgood` rise. Each step happens on a later cycle than the previous one.
- R5: `mem_pgood` is high only while `mem_en` is on and `mem_good` is high.
- R6: Edges on `s4_req_n` have no effect while `rsm_rst_n` is low, including an edge that arrives before power-up.
- R7: After a falling edge of `s4_req_n` in S0, both power-good outputs stay high until `plat_rst_n` and `idle_req_n` are both low. When that happens, the power-goods drop. `core_en` turns off one cycle later and `mem_en` one cycle after that. The suspend rails stay on.
- R8: A rising edge of `s4_req_n` during sleep entry, before both host signals are low, returns the block to S0 without any output changing.
- R9: `susp_off_ack` turns off all suspend rails and returns the block to G3, with `rsm_rst_n` low. This happens only in S4, with `rsm_rst_n` high and `s4_req_n` low. In any other state it has no effect.
- R10: If a rail's good flag falls while that rail is enabled, every enable and indication except `batt_low_n` goes low within three cycles.
- R11: `vcca_pgood` and `core_pgood` are always equal. Both are low whenever the suspend rails are off.
- R12: While `rst` is high, all enables, `rsm_rst_n` and both power-good outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| s4_req_n | input | 1 | Host S4 request, active low; its edges drive entry and exit |
| susp_off_ack | input | 1 | Host acknowledge to remove the suspend rails |
| plat_rst_n | input | 1 | Host platform reset, active low |
| idle_req_n | input | 1 | Host deep-idle request, active low |
| wake_req | input | 1 | Wake request; a rising edge leaves G3 |
| batt_ok | input | 1 | Battery sufficient to boot |
| sus_good | input | N_SUS | Suspend rails at nominal; bit 0 is the 3.3 V rail |
| mem_good | input | 1 | Memory rail at nominal |
| core_good | input | N_CORE | Core rails at nominal |
| sus_en | output | N_SUS | Suspend rail enables |
| mem_en | output | 1 | Memory rail enable |
| core_en | output | N_CORE | Core rail enables |
| rsm_rst_n | output | 1 | Resume reset to the host, active low |
| mem_pgood | output | 1 | Memory power good |
| vcca_pgood | output | 1 | Analog supply power good |
| core_pgood | output | 1 | Core power good |
| batt_low_n | output | 1 | Battery low indication, active low |

## Verification
Every result appears after the third rising edge that follows a change at the inputs. Two edges go to the synchronizer and one to the registered state and outputs. The power-down steps of R7 then follow at one cycle each. The bench drives inputs on the falling edge. A behavioural model advances at the rising edge on the same sampled inputs. Every output is compared with the model on the next falling edge, so the latency is checked on every cycle. The rail-ramp model also reacts on the falling edge. The directed checks in the scenario wait well past these latencies before they sample. The ordering checks compare the cycle numbers at which outputs rise and fall.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    ST_G3      = 4'd0,
    ST_SUS_ON  = 4'd1,
    ST_S4      = 4'd2,
    ST_MEM_UP  = 4'd3,
    ST_CORE_UP = 4'd4,
    ST_S0      = 4'd5,
    ST_SX      = 4'd6,
    ST_CORE_DN = 4'd7,
    ST_MEM_DN  = 4'd8
  } pwr_state_e;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pwr_seq_edge.sv
module pwr_seq_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= d;
  end

  assign rise = d & ~prev_q;
  assign fall = ~d & prev_q;

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int N_SUS  = 3,
  parameter int N_CORE = 2,
  localparam int NR    = N_SUS + 1 + N_CORE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake_rise,
  input  logic              s4_lvl,
  input  logic              s4_rise,
  input  logic              s4_fall,
  input  logic              ack,
  input  logic              plat_n,
  input  logic              idle_n,
  input  logic              batt,
  input  logic [N_SUS-1:0]  sus_good,
  input  logic              mem_good,
  input  logic [N_CORE-1:0] core_good,
  input  logic [NR-1:0]     good_fall,
  output logic [N_SUS-1:0]  sus_en,
  output logic              mem_en,
  output logic [N_CORE-1:0] core_en,
  output logic              rsm_n,
  output logic              mem_pg,
  output logic              pg,
  output logic              batlow_n
);

  pwr_state_e st_q, st_d;
  logic       fault;
  logic       sus_on_d, mem_on_d, core_on_d, pg_d;
  logic       s4_ok;

  assign fault = |({core_en, mem_en, sus_en} & good_fall);
  assign s4_ok = rsm_n;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_G3:      if (wake_rise && batt) st_d = ST_SUS_ON;
      ST_SUS_ON:  if (&sus_good) st_d = ST_S4;
      ST_S4: begin
        if (ack && !s4_lvl && s4_ok)   st_d = ST_G3;
        else if (s4_rise && s4_ok)     st_d = ST_MEM_UP;
      end
      ST_MEM_UP:  if (mem_good) st_d = ST_CORE_UP;
      ST_CORE_UP: if ((&core_good) && mem_good && (&sus_good)) st_d = ST_S0;
      ST_S0:      if (s4_fall && s4_ok) st_d = ST_SX;
      ST_SX: begin
        if (!plat_n && !idle_n)        st_d = ST_CORE_DN;
        else if (s4_rise && s4_ok)     st_d = ST_S0;
      end
      ST_CORE_DN: st_d = ST_MEM_DN;
      ST_MEM_DN:  st_d = ST_S4;
      default:    st_d = ST_G3;
    endcase
    if (fault) st_d = ST_G3;
  end

  always_comb begin
    sus_on_d  = (st_d != ST_G3);
    mem_on_d  = (st_d == ST_MEM_UP) || (st_d == ST_CORE_UP) || (st_d == ST_S0) ||
                (st_d == ST_SX) || (st_d == ST_CORE_DN) || (st_d == ST_MEM_DN);
    core_on_d = (st_d == ST_CORE_UP) || (st_d == ST_S0) ||
                (st_d == ST_SX) || (st_d == ST_CORE_DN);
    pg_d      = (st_d == ST_S0) || (st_d == ST_SX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_G3;
      sus_en   <= '0;
      mem_en   <= 1'b0;
      core_en  <= '0;
      rsm_n    <= 1'b0;
      mem_pg   <= 1'b0;
      pg       <= 1'b0;
      batlow_n <= 1'b0;
    end else begin
      st_q     <= st_d;
      sus_en   <= {N_SUS{sus_on_d}};
      mem_en   <= mem_on_d;
      core_en  <= {N_CORE{core_on_d}};
      rsm_n    <= sus_on_d && sus_good[0];
      mem_pg   <= mem_on_d && mem_good;
      pg       <= pg_d;
      batlow_n <= batt;
    end
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int N_SUS       = 3,
  parameter int N_CORE      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s4_req_n,
  input  logic              susp_off_ack,
  input  logic              plat_rst_n,
  input  logic              idle_req_n,
  input  logic              wake_req,
  input  logic              batt_ok,
  input  logic [N_SUS-1:0]  sus_good,
  input  logic              mem_good,
  input  logic [N_CORE-1:0] core_good,
  output logic [N_SUS-1:0]  sus_en,
  output logic              mem_en,
  output logic [N_CORE-1:0] core_en,
  output logic              rsm_rst_n,
  output logic              mem_pgood,
  output logic              vcca_pgood,
  output logic              core_pgood,
  output logic              batt_low_n
);

  localparam int NR = N_SUS + 1 + N_CORE;
  localparam int NH = 6;
  localparam int NI = NH + NR;

  logic [NI-1:0]     raw_in, syn_in;
  logic [NR-1:0]     good_s, good_rise_unused, good_fall;
  logic [1:0]        ev_s, ev_rise, ev_fall;
  logic              pg;

  assign raw_in = {core_good, mem_good, sus_good,
                   batt_ok, idle_req_n, plat_rst_n, susp_off_ack, s4_req_n, wake_req};

  pwr_seq_sync #(.W(NI), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  assign ev_s   = syn_in[1:0];
  assign good_s = syn_in[NI-1:NH];

  pwr_seq_edge #(.W(2)) u_host_edge (
    .clk  (clk),
    .rst  (rst),
    .d    (ev_s),
    .rise (ev_rise),
    .fall (ev_fall)
  );

  pwr_seq_edge #(.W(NR)) u_rail_edge (
    .clk  (clk),
    .rst  (rst),
    .d    (good_s),
    .rise (good_rise_unused),
    .fall (good_fall)
  );

  pwr_seq_fsm #(.N_SUS(N_SUS), .N_CORE(N_CORE)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wake_rise (ev_rise[0]),
    .s4_lvl    (syn_in[1]),
    .s4_rise   (ev_rise[1]),
    .s4_fall   (ev_fall[1]),
    .ack       (syn_in[2]),
    .plat_n    (syn_in[3]),
    .idle_n    (syn_in[4]),
    .batt      (syn_in[5]),
    .sus_good  (good_s[N_SUS-1:0]),
    .mem_good  (good_s[N_SUS]),
    .core_good (good_s[NR-1:N_SUS+1]),
    .good_fall ({good_fall[NR-1:N_SUS+1], good_fall[N_SUS], good_fall[N_SUS-1:0]}),
    .sus_en    (sus_en),
    .mem_en    (mem_en),
    .core_en   (core_en),
    .rsm_n     (rsm_rst_n),
    .mem_pg    (mem_pgood),
    .pg        (pg),
    .batlow_n  (batt_low_n)
  );

  assign vcca_pgood = pg;
  assign core_pgood = pg;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int N_SUS  = 3,
  parameter int N_CORE = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [N_SUS-1:0]  sus_en,
  input logic              mem_en,
  input logic [N_CORE-1:0] core_en,
  input logic              rsm_rst_n,
  input logic              mem_pgood,
  input logic              vcca_pgood,
  input logic              core_pgood
);

  // R11
  pg_pair_chk: assert property (@(posedge clk) disable iff (rst)
    vcca_pgood == core_pgood);

  // R11
  pg_g3_chk: assert property (@(posedge clk) disable iff (rst)
    (sus_en == '0) |-> !core_pgood);

  // R3
  rsm_rail_chk: assert property (@(posedge clk) disable iff (rst)
    rsm_rst_n |-> sus_en[0]);

  // R4
  core_after_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (core_en != '0) |-> mem_en);

  // R4
  pg_needs_core_chk: assert property (@(posedge clk) disable iff (rst)
    core_pgood |-> (&core_en));

  // R5
  mem_pg_chk: assert property (@(posedge clk) disable iff (rst)
    mem_pgood |-> mem_en);

  // R7
  mem_off_last_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_en) && (sus_en != '0)) |-> (core_en == '0));

endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.N_SUS(N_SUS), .N_CORE(N_CORE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sus_en     (sus_en),
  .mem_en     (mem_en),
  .core_en    (core_en),
  .rsm_rst_n  (rsm_rst_n),
  .mem_pgood  (mem_pgood),
  .vcca_pgood (vcca_pgood),
  .core_pgood (core_pgood)
);

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;

  localparam int N_SUS = 3, N_CORE = 2;
  localparam int D_SUS = 4, D_MEM = 6, D_CORE = 5;
  localparam int M_G3 = 0, M_SUSON = 1, M_S4 = 2, M_MUP = 3, M_CUP = 4,
                 M_S0 = 5, M_SX = 6, M_CDN = 7, M_MDN = 8;

  logic clk = 0, rst = 1;
  logic s4_req_n = 1, susp_off_ack = 0, plat_rst_n = 1, idle_req_n = 1;
  logic wake_req = 0, batt_ok = 0;
  logic [N_SUS-1:0]  sus_good = '0;
  logic              mem_good = 0;
  logic [N_CORE-1:0] core_good = '0;
  logic [N_SUS-1:0]  sus_en;
  logic              mem_en;
  logic [N_CORE-1:0] core_en;
  logic rsm_rst_n, mem_pgood, vcca_pgood, core_pgood, batt_low_n;
  logic kill_core = 0;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_seq_ctrl #(.N_SUS(N_SUS), .N_CORE(N_CORE)) u_dut (
    .clk(clk), .rst(rst), .s4_req_n(s4_req_n), .susp_off_ack(susp_off_ack),
    .plat_rst_n(plat_rst_n), .idle_req_n(idle_req_n), .wake_req(wake_req),
    .batt_ok(batt_ok), .sus_good(sus_good), .mem_good(mem_good), .core_good(core_good),
    .sus_en(sus_en), .mem_en(mem_en), .core_en(core_en), .rsm_rst_n(rsm_rst_n),
    .mem_pgood(mem_pgood), .vcca_pgood(vcca_pgood), .core_pgood(core_pgood),
    .batt_low_n(batt_low_n));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  logic [11:0] in_now;
  assign in_now = {core_good, mem_good, sus_good, batt_ok, idle_req_n, plat_rst_n,
                   susp_off_ack, s4_req_n, wake_req};
  logic [11:0] m1, m2, mp;
  int ms, nx;
  bit m_sus, m_mem, m_core, m_rs, m_dram, m_pg, m_bat, flt, wr, sr, sf;

  always @(posedge clk) begin
    if (rst) begin
      m1 = '0; m2 = '0; mp = '0; ms = M_G3;
      m_sus = 0; m_mem = 0; m_core = 0; m_rs = 0; m_dram = 0; m_pg = 0; m_bat = 0;
    end else begin
      wr = m2[0] && !mp[0];
      sr = m2[1] && !mp[1];
      sf = !m2[1] && mp[1];
      flt = 0;
      for (int i = 0; i < 3; i++) if (m_sus && mp[6+i] && !m2[6+i]) flt = 1;
      if (m_mem && mp[9] && !m2[9]) flt = 1;
      for (int i = 0; i < 2; i++) if (m_core && mp[10+i] && !m2[10+i]) flt = 1;
      nx = ms;
      if (ms == M_G3 && wr && m2[5]) nx = M_SUSON;
      else if (ms == M_SUSON && m2[8:6] == 3'b111) nx = M_S4;
      else if (ms == M_S4 && m2[2] && !m2[1] && m_rs) nx = M_G3;
      else if (ms == M_S4 && sr && m_rs) nx = M_MUP;
      else if (ms == M_MUP && m2[9]) nx = M_CUP;
      else if (ms == M_CUP && m2[11:6] == 6'h3f) nx = M_S0;
      else if (ms == M_S0 && sf && m_rs) nx = M_SX;
      else if (ms == M_SX && !m2[3] && !m2[4]) nx = M_CDN;
      else if (ms == M_SX && sr && m_rs) nx = M_S0;
      else if (ms == M_CDN) nx = M_MDN;
      else if (ms == M_MDN) nx = M_S4;
      if (flt) nx = M_G3;
      ms = nx;
      m_sus  = (nx != M_G3);
      m_mem  = (nx >= M_MUP);
      m_core = (nx >= M_CUP && nx <= M_CDN);
      m_pg   = (nx == M_S0 || nx == M_SX);
      m_rs   = m_sus && m2[6];
      m_dram = m_mem && m2[9];
      m_bat  = m2[5];
      mp = m2; m2 = m1; m1 = in_now;
    end
  end

  // timestamps for ordering checks
  int t_mem_up, t_core_up, t_pg_up, t_pg_dn, t_core_dn, t_mem_dn;
  logic p_mem = 0, p_core = 0, p_pg = 0;
  int c_sus [N_SUS];
  int c_mem = 0;
  int c_core [N_CORE];

  initial begin
    for (int i = 0; i < N_SUS; i++) c_sus[i] = 0;
    for (int i = 0; i < N_CORE; i++) c_core[i] = 0;
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(sus_en == {N_SUS{m_sus}}, "R2", "sus_en", sus_en, {N_SUS{m_sus}});
      chk(mem_en == m_mem, "R4", "mem_en", mem_en, m_mem);
      chk(core_en == {N_CORE{m_core}}, "R4", "core_en", core_en, {N_CORE{m_core}});
      chk(rsm_rst_n == m_rs, "R3", "rsm_rst_n", rsm_rst_n, m_rs);
      chk(mem_pgood == m_dram, "R5", "mem_pgood", mem_pgood, m_dram);
      chk(core_pgood == m_pg, "R7", "core_pgood", core_pgood, m_pg);
      chk(vcca_pgood == core_pgood, "R11", "vcca_pgood", vcca_pgood, core_pgood);
      chk(batt_low_n == m_bat, "R1", "batt_low_n", batt_low_n, m_bat);
    end
    if (mem_en && !p_mem) t_mem_up = cyc;
    if (!mem_en && p_mem) t_mem_dn = cyc;
    if (core_en[0] && !p_core) t_core_up = cyc;
    if (!core_en[0] && p_core) t_core_dn = cyc;
    if (core_pgood && !p_pg) t_pg_up = cyc;
    if (!core_pgood && p_pg) t_pg_dn = cyc;
    p_mem = mem_en; p_core = core_en[0]; p_pg = core_pgood;
    // rail ramp model
    for (int i = 0; i < N_SUS; i++) begin
      if (sus_en[i]) begin c_sus[i]++; sus_good[i] = (c_sus[i] >= D_SUS); end
      else begin c_sus[i] = 0; sus_good[i] = 0; end
    end
    if (mem_en) begin c_mem++; mem_good = (c_mem >= D_MEM); end
    else begin c_mem = 0; mem_good = 0; end
    for (int i = 0; i < N_CORE; i++) begin
      if (core_en[i] && !kill_core) begin c_core[i]++; core_good[i] = (c_core[i] >= D_CORE); end
      else begin c_core[i] = 0; core_good[i] = 0; end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 20000);
    chk(0, "WDOG", "watchdog expired", cyc, 20000);
    finish_run();
  end

  initial begin
    wait_cyc(5);
    // R12 reset state
    chk(sus_en == '0 && mem_en == 0 && core_en == '0, "R12", "enables in reset",
        {sus_en, mem_en, core_en}, 0);
    chk(rsm_rst_n == 0 && core_pgood == 0 && vcca_pgood == 0, "R12", "indications in reset",
        {rsm_rst_n, core_pgood, vcca_pgood}, 0);
    rst = 0;
    wait_cyc(5);
    // R1 battery low
    chk(batt_low_n == 0, "R1", "batt_low_n with weak battery", batt_low_n, 0);
    // R2 wake blocked by weak battery
    wake_req = 1; wait_cyc(2); wake_req = 0; wait_cyc(20);
    chk(sus_en == '0, "R2", "wake ignored on weak battery", sus_en, 0);
    // R6 host S4 edges while resume reset is low
    s4_req_n = 0; wait_cyc(3); s4_req_n = 1; wait_cyc(3); s4_req_n = 0; wait_cyc(5);
    chk(sus_en == '0 && rsm_rst_n == 0, "R3", "still in G3", {sus_en, rsm_rst_n}, 0);
    batt_ok = 1; wait_cyc(2);
    chk(batt_low_n == 0, "R1", "latency not yet elapsed", batt_low_n, 0);
    wait_cyc(1);
    chk(batt_low_n == 1, "R1", "batt_low_n after three edges", batt_low_n, 1);
    wake_req = 1; wait_cyc(2); wake_req = 0; wait_cyc(40);
    chk(sus_en == '1, "R2", "suspend rails on after wake", sus_en, 7);
    chk(rsm_rst_n == 1, "R3", "resume reset released", rsm_rst_n, 1);
    chk(mem_en == 0, "R6", "earlier S4 edges had no effect", mem_en, 0);
    // R4 power-up order
    t_mem_up = -1; t_core_up = -1; t_pg_up = -1;
    s4_req_n = 1; wait_cyc(60);
    chk(core_pgood == 1, "R4", "power good reached", core_pgood, 1);
    chk(t_mem_up > 0 && t_core_up > t_mem_up, "R4", "core after memory", t_core_up, t_mem_up + 1);
    chk(t_pg_up > t_core_up, "R4", "power good after core", t_pg_up, t_core_up + 1);
    chk(mem_pgood == 1, "R5", "memory power good in S0", mem_pgood, 1);
    // R9 acknowledge ignored outside S4
    susp_off_ack = 1; wait_cyc(3); susp_off_ack = 0; wait_cyc(10);
    chk(sus_en == '1 && core_pgood == 1, "R9", "ack ignored in S0", {sus_en, core_pgood}, 15);
    // R7 only one host signal low
    t_pg_dn = -1;
    s4_req_n = 0; plat_rst_n = 0; wait_cyc(30);
    chk(core_pgood == 1 && vcca_pgood == 1, "R7", "power good held with one low",
        {core_pgood, vcca_pgood}, 3);
    // R8 exit back to S0
    s4_req_n = 1; wait_cyc(10); plat_rst_n = 1; wait_cyc(10);
    chk(t_pg_dn == -1 && core_pgood == 1 && core_en == '1, "R8", "returned to S0 unchanged",
        t_pg_dn, -1);
    // R7 full sleep entry
    t_core_dn = -1; t_mem_dn = -1;
    s4_req_n = 0; wait_cyc(6); plat_rst_n = 0; idle_req_n = 0; wait_cyc(20);
    chk(core_pgood == 0 && core_en == '0 && mem_en == 0, "R7", "rails down",
        {core_pgood, core_en, mem_en}, 0);
    chk(t_pg_dn > 0 && t_core_dn == t_pg_dn + 1 && t_mem_dn == t_core_dn + 1, "R7",
        "reverse order one cycle apart", t_mem_dn - t_pg_dn, 2);
    chk(sus_en == '1 && rsm_rst_n == 1, "R7", "suspend rails kept", {sus_en, rsm_rst_n}, 15);
    // R9 acknowledge honoured in S4
    susp_off_ack = 1; wait_cyc(10); susp_off_ack = 0;
    chk(sus_en == '0 && rsm_rst_n == 0, "R9", "suspend rails off", {sus_en, rsm_rst_n}, 0);
    chk(core_pgood == 0 && vcca_pgood == 0, "R11", "power good low in G3",
        {core_pgood, vcca_pgood}, 0);
    // R10 rail fault
    plat_rst_n = 1; idle_req_n = 1; wait_cyc(5);
    wake_req = 1; wait_cyc(2); wake_req = 0; wait_cyc(40);
    s4_req_n = 1; wait_cyc(60);
    chk(core_pgood == 1, "R10", "back in S0 before fault", core_pgood, 1);
    kill_core = 1; wait_cyc(6);
    chk(sus_en == '0 && mem_en == 0 && core_en == '0 && rsm_rst_n == 0 && core_pgood == 0
        && mem_pgood == 0, "R10", "all off after rail fault",
        {sus_en, mem_en, core_en, rsm_rst_n, core_pgood, mem_pgood}, 0);
    kill_core = 0; wait_cyc(5);
    finish_run();
  end

endmodule